// File: doc/BRIEF.md
# Montgomery Ladder Scalar Sequencer

This block is the control side of an elliptic-curve scalar multiplication. It accepts a scalar of up to `KW` bits with a start strobe and then steers an external point-arithmetic engine through a ladder whose command stream does not depend on the scalar's bit values. The engine holds two point slots, numbered 0 and 1. It sees only an opcode, a source slot and a destination slot, and it answers each command with an acknowledge. The field arithmetic lives entirely inside that engine.

After start, the sequencer spends a fixed number of cycles finding the most significant set bit of the scalar. It then loads the base point into slot 0 and doubles it into slot 1. That doubling is left out in fixed-base mode, where the doubled point is already present. For every bit below the leading one it issues a single combined add-then-double command. The bit value changes only which slot is the source and which is the destination. An all-zero scalar ends the run with an error indication and no commands.

Top module: `ladder_seq`

## Requirements
- R1: While reset is held and after it is released, `busy`, `cmd_valid`, `done` and `err` are low and `cmd_op` is 0.
- R2: `start` is acted on only while `busy` is low. `scalar` and `fixed_base` are sampled in that cycle only. A `start` while busy, including the cycle in which `done` is high, is ignored, and `busy` is low in the cycle after `done`.
- R3: The leading-bit scan lasts exactly `KW` cycles for every scalar value. The first command, or the zero-scalar completion, appears in the `KW+1`-th cycle after the clock edge that samples `start`. No command is presented before that cycle.
- R4: The first command is a load (`cmd_op` = 1) with source slot 0 and destination slot 0.
- R5: When `fixed_base` was 0 at start, the second command is a doubling (`cmd_op` = 2) with source slot 0 and destination slot 1. When `fixed_base` was 1, no doubling is issued.
- R6: With t-1 the position of the highest set bit, one ladder command (`cmd_op` = 3) follows for each bit i from t-2 down to 0, in descending order. Its source is k_i, the slot that is doubled, and its destination is 1-k_i, the slot that receives the sum. Command count and timing depend only on t and the mode.
- R7: A command holds `cmd_valid` and its fields stable until the edge on which `cmd_ack` is high. The next command is presented in the following cycle. `cmd_ack` while `cmd_valid` is low has no effect.
- R8: `done` is high for exactly one cycle, the cycle after the edge that accepts the last command.
- R9: For an all-zero scalar no command is issued, and `done` and `err` are high together for one cycle at the time given in R3. `err` is never high without `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a multiplication when idle |
| fixed_base | input | 1 | 1: doubled base point is preloaded, skip the doubling |
| scalar | input | KW | Scalar multiplier |
| cmd_valid | output | 1 | A command is presented to the engine |
| cmd_op | output | 2 | 1 load, 2 double, 3 ladder step, 0 none |
| cmd_src | output | 1 | Source slot index |
| cmd_dst | output | 1 | Destination slot index |
| cmd_ack | input | 1 | Engine accepts the presented command |
| busy | output | 1 | A multiplication is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | High with `done` when the scalar was zero |

## Verification
Two pairs of events can share a cycle. A new start request can arrive in the very cycle that `done` is pulsed, and an acknowledge can arrive while the sequencer is still scanning and has nothing to offer. The bench raises `start` exactly in the `done` cycle and again in the middle of the scan, and pulses `cmd_ack` during the scan. It changes `scalar` after the sampling cycle. It then expects the output trace to continue unchanged: the command list and cycle placement predicted by its own ladder model from the originally sampled scalar, followed by an idle sequencer with no second scan. The engine acknowledge delay is randomised from zero to several cycles, so both back-to-back acceptance and held commands are compared on every clock.

// File: rtl/ladder_seq.sv
module ladder_seq #(
  parameter int KW = 192
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          fixed_base,
  input  logic [KW-1:0] scalar,
  output logic          cmd_valid,
  output logic [1:0]    cmd_op,
  output logic          cmd_src,
  output logic          cmd_dst,
  input  logic          cmd_ack,
  output logic          busy,
  output logic          done,
  output logic          err
);
  localparam int IW = $clog2(KW);

  typedef enum logic [2:0] {S_IDLE, S_SCAN, S_LOAD, S_DBL, S_STEP, S_FIN} st_t;

  st_t           st;
  logic [KW-1:0] k_q;
  logic [IW-1:0] cnt;
  logic [IW-1:0] top;
  logic          found;
  logic          fb_q;
  logic          err_q;

  wire fire = cmd_valid & cmd_ack;
  wire bit_k = k_q[cnt];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      k_q   <= '0;
      cnt   <= '0;
      top   <= '0;
      found <= 1'b0;
      fb_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          k_q   <= scalar;
          fb_q  <= fixed_base;
          cnt   <= IW'(KW - 1);
          top   <= '0;
          found <= 1'b0;
          err_q <= 1'b0;
          st    <= S_SCAN;
        end
        S_SCAN: begin
          if (bit_k && !found) begin
            found <= 1'b1;
            top   <= cnt;
          end
          if (cnt == '0) begin
            if (found || bit_k) st <= S_LOAD;
            else begin
              err_q <= 1'b1;
              st    <= S_FIN;
            end
          end else begin
            cnt <= cnt - IW'(1);
          end
        end
        S_LOAD, S_DBL: if (fire) begin
          if (st == S_LOAD && !fb_q) st <= S_DBL;
          else if (top == '0) st <= S_FIN;
          else begin
            cnt <= top - IW'(1);
            st  <= S_STEP;
          end
        end
        S_STEP: if (fire) begin
          if (cnt == '0) st <= S_FIN;
          else cnt <= cnt - IW'(1);
        end
        S_FIN: begin
          err_q <= 1'b0;
          st    <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cmd_valid = (st == S_LOAD) || (st == S_DBL) || (st == S_STEP);
  assign cmd_op    = (st == S_LOAD) ? 2'd1 :
                     (st == S_DBL)  ? 2'd2 :
                     (st == S_STEP) ? 2'd3 : 2'd0;
  assign cmd_src   = (st == S_STEP) & bit_k;
  assign cmd_dst   = (st == S_DBL) | ((st == S_STEP) & ~bit_k);
  assign busy      = (st != S_IDLE);
  assign done      = (st == S_FIN);
  assign err       = (st == S_FIN) & err_q;
endmodule

module ladder_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic       cmd_src,
  input logic       cmd_dst,
  input logic       cmd_ack,
  input logic       busy,
  input logic       done,
  input logic       err
);
  a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ack |=> cmd_valid && $stable(cmd_op) && $stable(cmd_src) && $stable(cmd_dst));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r2_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  a_r9_err_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid && !done && !err);

  a_r4_load_slots: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 2'd1 |-> !cmd_src && !cmd_dst);

  a_r5_dbl_slots: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 2'd2 |-> !cmd_src && cmd_dst);

  a_r6_step_cross: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 2'd3 |-> cmd_src != cmd_dst);

  a_r7_valid_has_op: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_op != 2'd0);
endmodule

bind ladder_seq ladder_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_src(cmd_src), .cmd_dst(cmd_dst), .cmd_ack(cmd_ack),
  .busy(busy), .done(done), .err(err)
);

// File: tb/ladder_seq_test.sv
`timescale 1ns/1ps
module ladder_seq_test;
  localparam int KW = 192;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          fixed_base = 1'b0;
  logic [KW-1:0] scalar = '0;
  logic          cmd_ack = 1'b0;
  logic          cmd_valid, cmd_src, cmd_dst, busy, done, err;
  logic [1:0]    cmd_op;

  int vectors = 0;
  int fails = 0;

  always #2 clk = ~clk;

  ladder_seq #(.KW(KW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .fixed_base(fixed_base),
    .scalar(scalar), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_src(cmd_src), .cmd_dst(cmd_dst), .cmd_ack(cmd_ack),
    .busy(busy), .done(done), .err(err)
  );

  function automatic logic [7:0] mk(int v, int op, int s, int d, int dn, int e, int b);
    return {v[0], op[1:0], s[0], d[0], dn[0], e[0], b[0]};
  endfunction

  function automatic logic [KW-1:0] rnd();
    logic [KW-1:0] r = '0;
    for (int i = 0; i < KW; i += 32) r = (r << 32) | KW'($urandom);
    return r;
  endfunction

  task automatic chk(string req, logic [7:0] exp);
    logic [7:0] got = {cmd_valid, cmd_op, cmd_src, cmd_dst, done, err, busy};
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s at %0t: got {v,op,src,dst,done,err,busy}=%b expected %b", req, $time, got, exp);
    end
  endtask

  task automatic run(input logic [KW-1:0] k, input bit fb, input int maxw);
    int ops[$];
    int srcs[$];
    int dsts[$];
    int t = -1;
    int w;
    string tag;
    for (int i = KW - 1; i >= 0; i--) if (k[i] && t < 0) t = i;
    if (t >= 0) begin
      ops.push_back(1); srcs.push_back(0); dsts.push_back(0);
      if (!fb) begin ops.push_back(2); srcs.push_back(0); dsts.push_back(1); end
      for (int i = t - 1; i >= 0; i--) begin
        ops.push_back(3); srcs.push_back(int'(k[i])); dsts.push_back(1 - int'(k[i]));
      end
    end
    scalar = k; fixed_base = fb; start = 1'b1;
    @(negedge clk);
    start = 1'b0; scalar = rnd(); fixed_base = ~fb;
    for (int c = 0; c < KW; c++) begin
      chk("R3 scan quiet", mk(0,0,0,0,0,0,1));
      start   = (c == 7);
      cmd_ack = (c == 9);
      @(negedge clk);
    end
    start = 1'b0; cmd_ack = 1'b0;
    if (t < 0) begin
      chk("R9 zero scalar done+err", mk(0,0,0,0,1,1,1));
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R9 idle after error", mk(0,0,0,0,0,0,0));
      @(negedge clk);
      chk("R2 start in done ignored", mk(0,0,0,0,0,0,0));
      return;
    end
    w = $urandom_range(maxw, 0);
    for (int p = 0; p < ops.size(); ) begin
      if (p == 0) tag = "R4 load";
      else if (p == 1 && !fb) tag = "R5 double";
      else tag = "R6 ladder step";
      if (w > 0) tag = {tag, " R7 held"};
      chk(tag, mk(1, ops[p], srcs[p], dsts[p], 0, 0, 1));
      if (w == 0) begin
        cmd_ack = 1'b1; p++; w = $urandom_range(maxw, 0);
      end else begin
        cmd_ack = 1'b0; w--;
      end
      @(negedge clk);
    end
    cmd_ack = 1'b0;
    chk("R8 done pulse", mk(0,0,0,0,1,0,1));
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R8 done single", mk(0,0,0,0,0,0,0));
    @(negedge clk);
    chk("R2 start in done ignored", mk(0,0,0,0,0,0,0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog expired: got hung run expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", mk(0,0,0,0,0,0,0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", mk(0,0,0,0,0,0,0));
    cmd_ack = 1'b1;
    @(negedge clk);
    cmd_ack = 1'b0;
    chk("R7 stray ack idle", mk(0,0,0,0,0,0,0));

    run('0, 1'b0, 0);
    run(KW'(1), 1'b0, 0);
    run(KW'(1), 1'b1, 2);
    run(KW'(11), 1'b0, 3);
    run({1'b1, {(KW-1){1'b0}}}, 1'b0, 0);
    run({KW{1'b1}}, 1'b1, 1);
    run({KW{1'b1}}, 1'b0, 0);
    run({1'b0, 1'b1, {(KW-2){1'b0}}}, 1'b1, 0);
    for (int r = 0; r < 14; r++) begin
      logic [KW-1:0] k = rnd() >> $urandom_range(KW - 2, 0);
      run(k, bit'(r % 2), r % 4);
    end
    run('0, 1'b1, 2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule